// File: doc/BRIEF.md
# Fault Latch and Standby Controller

This block gathers the fault and event indications of a dual-LED flash driver and latches them into two 8-bit flag bytes. From these flags it decides whether the driver must be held in standby, and it raises a clear-mode request while any standby-forcing flag is latched. The mode logic elsewhere uses this request to clear its mode bits. Operation can resume only after software has read the flag bytes, because a read clears the byte that was read.

Most detectors set their flag on the first clock in which they are high. The two short detectors work differently: each must stay high for a run of microsecond ticks before its flag is set, and the output short needs a longer run than an LED short. The overvoltage flag waits for the third rising edge of its comparator. Current limit, transmit, flash timeout and input-voltage-monitor trips are recorded but never force standby. A software reset input and the active-low hardware reset clear every flag and every counter.

Top module: `faultSupervisor`

## Requirements
- R1: After reset, both flag bytes read 0x00 and clearMode is low.
- R2: In flags1 each input sets one bit in the cycle after it is high, and the bit stays set after the input drops. The bits are: 7 transmit event, 6 output short, 5 LED1 short, 4 LED2 short, 3 current limit, 2 thermal shutdown, 1 undervoltage, 0 flash timeout.
- R3: In flags2 the bits are: 4 NTC short, 3 NTC open, 2 voltage-monitor trip, 1 overvoltage, 0 temperature trip. Bits 7 to 5 always read 0.
- R4: clearMode is high while any of these flags is set: output short, LED1 short, LED2 short, thermal shutdown, undervoltage, NTC short, NTC open, overvoltage, temperature trip.
- R5: Transmit, current limit, flash timeout and voltage-monitor flags do not raise clearMode.
- R6: A one-cycle read strobe clears its flag byte in the next cycle. clearMode drops only once both bytes hold no standby-forcing flag.
- R7: If a detector is still high when its byte is read, the set takes priority, so the flag and clearMode stay set.
- R8: An LED short flag is set on the 256th usTick for which that short input, driverActive and ledShortEn are all high. If any of the three drops, the count restarts from zero. Cycles without usTick do not count.
- R9: The output-short flag is set on the 2048th consecutive qualifying usTick while driverActive is high. ledShortEn does not gate it.
- R10: The overvoltage flag is set on the third rising edge of ovpDet while driverActive is high. The edge count returns to zero when driverActive is low or when either flag byte is read.
- R11: The NTC short and NTC open inputs set their flags only while ntcShortEn or ntcOpenEn, respectively, is high.
- R12: swReset clears both flag bytes and all counters in the next cycle. This overrides any set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (hardware enable) |
| swReset | input | 1 | Software reset, clears flags and counters |
| usTick | input | 1 | One-cycle pulse every microsecond |
| driverActive | input | 1 | Torch, flash or IR output is running |
| ledShortEn | input | 1 | Enables LED short detection |
| ntcShortEn | input | 1 | Enables NTC short fault |
| ntcOpenEn | input | 1 | Enables NTC open fault |
| txEvt | input | 1 | Transmit event seen during flash |
| outShortDet | input | 1 | Output short comparator |
| led1ShortDet | input | 1 | LED1 short comparator |
| led2ShortDet | input | 1 | LED2 short comparator |
| curLimDet | input | 1 | Current limit hit |
| tsdDet | input | 1 | Die over-temperature |
| uvloDet | input | 1 | Input undervoltage |
| flashTimeoutEvt | input | 1 | Flash timer expired |
| ntcShortDet | input | 1 | NTC input below short level |
| ntcOpenDet | input | 1 | NTC input above open level |
| ivfmTripDet | input | 1 | Input voltage monitor tripped |
| ovpDet | input | 1 | Overvoltage comparator |
| tempTripDet | input | 1 | NTC below temperature threshold |
| rdFlags1 | input | 1 | Read strobe for flag byte 1 |
| rdFlags2 | input | 1 | Read strobe for flag byte 2 |
| flags1 | output | 8 | Flag byte 1 |
| flags2 | output | 8 | Flag byte 2 |
| clearMode | output | 1 | Request to force standby |

## Verification
The assertions assume that every detector input is synchronous to clk and already free of metastability. They also assume that a read strobe is a single-cycle pulse not issued at the same time as swReset. The bench drives every input just after the falling clock edge and holds each read strobe for exactly one cycle. It pulses the overvoltage input with a low cycle between edges, so every rising edge the comparator makes is counted.

// File: rtl/faultPkg.sv
package faultPkg;
  // bit positions in flag byte 1
  localparam int F1_TX      = 7;
  localparam int F1_OSHORT  = 6;
  localparam int F1_L1SHORT = 5;
  localparam int F1_L2SHORT = 4;
  localparam int F1_CURLIM  = 3;
  localparam int F1_TSD     = 2;
  localparam int F1_UVLO    = 1;
  localparam int F1_TMO     = 0;
  // bit positions in the live part of flag byte 2
  localparam int F2_NSHORT  = 4;
  localparam int F2_NOPEN   = 3;
  localparam int F2_IVFM    = 2;
  localparam int F2_OVP     = 1;
  localparam int F2_TEMP    = 0;

  localparam int F2_LIVE = 5;

  // flags that hold the driver in standby
  localparam logic [7:0]         F1_STANDBY = 8'b0111_0110;
  localparam logic [F2_LIVE-1:0] F2_STANDBY = 5'b1_1011;

  typedef struct packed {
    logic [7:0]         setF1;
    logic [F2_LIVE-1:0] setF2;
    logic               rdF1;
    logic               rdF2;
    logic               wipe;
  } flagStrobes_t;
endpackage

// File: rtl/deglitchTimer.sv
module deglitchTimer #(
  parameter int Ticks = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic wipe,
  input  logic qual,
  input  logic tick,
  output logic fire
);
  localparam int CW = $clog2(Ticks + 1);
  localparam logic [CW-1:0] LAST = CW'(Ticks - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (wipe || !qual)
      cnt <= '0;
    else if (tick && cnt != LAST)
      cnt <= cnt + CW'(1);
  end

  // saturates at LAST, so a held fault keeps re-asserting on each tick
  assign fire = qual && tick && !wipe && (cnt == LAST);
endmodule

// File: rtl/risingEdgeCounter.sv
module risingEdgeCounter #(
  parameter int Edges = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic zero,
  input  logic sig,
  output logic fire
);
  localparam int CW = $clog2(Edges + 1);
  localparam logic [CW-1:0] LAST = CW'(Edges - 1);

  logic          sigPrev;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise = sig && !sigPrev;
  assign fire = rise && !zero && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigPrev <= 1'b0;
      cnt     <= '0;
    end else begin
      sigPrev <= sig;
      if (zero || fire)
        cnt <= '0;
      else if (rise)
        cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/faultDetectCtl.sv
module faultDetectCtl
  import faultPkg::*;
#(
  parameter int LedShortTicks = 256,
  parameter int OutShortTicks = 2048,
  parameter int OvpEdges      = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swReset,
  input  logic         usTick,
  input  logic         driverActive,
  input  logic         ledShortEn,
  input  logic         ntcShortEn,
  input  logic         ntcOpenEn,
  input  logic         txEvt,
  input  logic         outShortDet,
  input  logic         led1ShortDet,
  input  logic         led2ShortDet,
  input  logic         curLimDet,
  input  logic         tsdDet,
  input  logic         uvloDet,
  input  logic         flashTimeoutEvt,
  input  logic         ntcShortDet,
  input  logic         ntcOpenDet,
  input  logic         ivfmTripDet,
  input  logic         ovpDet,
  input  logic         tempTripDet,
  input  logic         rdFlags1,
  input  logic         rdFlags2,
  output flagStrobes_t strobes
);
  localparam int NSHORT = 3;

  logic [NSHORT-1:0] shortQual;
  logic [NSHORT-1:0] shortFire;
  logic              ovpFire;
  logic              ovpZero;

  // index 0: output short, 1: LED1 short, 2: LED2 short
  assign shortQual[0] = outShortDet  && driverActive;
  assign shortQual[1] = led1ShortDet && driverActive && ledShortEn;
  assign shortQual[2] = led2ShortDet && driverActive && ledShortEn;

  for (genvar g = 0; g < NSHORT; g++) begin : gShort
    localparam int T = (g == 0) ? OutShortTicks : LedShortTicks;
    deglitchTimer #(.Ticks(T)) uDeglitch (
      .clk  (clk),
      .rstN (rstN),
      .wipe (swReset),
      .qual (shortQual[g]),
      .tick (usTick),
      .fire (shortFire[g])
    );
  end

  assign ovpZero = !driverActive || rdFlags1 || rdFlags2 || swReset;

  risingEdgeCounter #(.Edges(OvpEdges)) uOvpEdges (
    .clk  (clk),
    .rstN (rstN),
    .zero (ovpZero),
    .sig  (ovpDet),
    .fire (ovpFire)
  );

  always_comb begin
    strobes = '0;
    strobes.setF1[F1_TX]      = txEvt;
    strobes.setF1[F1_OSHORT]  = shortFire[0];
    strobes.setF1[F1_L1SHORT] = shortFire[1];
    strobes.setF1[F1_L2SHORT] = shortFire[2];
    strobes.setF1[F1_CURLIM]  = curLimDet;
    strobes.setF1[F1_TSD]     = tsdDet;
    strobes.setF1[F1_UVLO]    = uvloDet;
    strobes.setF1[F1_TMO]     = flashTimeoutEvt;
    strobes.setF2[F2_NSHORT]  = ntcShortDet && ntcShortEn;
    strobes.setF2[F2_NOPEN]   = ntcOpenDet && ntcOpenEn;
    strobes.setF2[F2_IVFM]    = ivfmTripDet;
    strobes.setF2[F2_OVP]     = ovpFire;
    strobes.setF2[F2_TEMP]    = tempTripDet;
    strobes.rdF1              = rdFlags1;
    strobes.rdF2              = rdFlags2;
    strobes.wipe              = swReset;
  end
endmodule

// File: rtl/flagDatapath.sv
module flagDatapath
  import faultPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  flagStrobes_t strobes,
  output logic [7:0]   flags1,
  output logic [7:0]   flags2,
  output logic         clearMode
);
  logic [7:0]         f1Q;
  logic [F2_LIVE-1:0] f2Q;

  // swReset beats everything; a set beats a read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      f1Q <= '0;
      f2Q <= '0;
    end else if (strobes.wipe) begin
      f1Q <= '0;
      f2Q <= '0;
    end else begin
      f1Q <= (strobes.rdF1 ? 8'h00 : f1Q) | strobes.setF1;
      f2Q <= (strobes.rdF2 ? '0 : f2Q) | strobes.setF2;
    end
  end

  assign flags1    = f1Q;
  assign flags2    = {{(8-F2_LIVE){1'b0}}, f2Q};
  assign clearMode = |(f1Q & F1_STANDBY) || |(f2Q & F2_STANDBY);
endmodule

// File: rtl/faultSupervisor.sv
module faultSupervisor
  import faultPkg::*;
#(
  parameter int LedShortTicks = 256,
  parameter int OutShortTicks = 2048,
  parameter int OvpEdges      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       usTick,
  input  logic       driverActive,
  input  logic       ledShortEn,
  input  logic       ntcShortEn,
  input  logic       ntcOpenEn,
  input  logic       txEvt,
  input  logic       outShortDet,
  input  logic       led1ShortDet,
  input  logic       led2ShortDet,
  input  logic       curLimDet,
  input  logic       tsdDet,
  input  logic       uvloDet,
  input  logic       flashTimeoutEvt,
  input  logic       ntcShortDet,
  input  logic       ntcOpenDet,
  input  logic       ivfmTripDet,
  input  logic       ovpDet,
  input  logic       tempTripDet,
  input  logic       rdFlags1,
  input  logic       rdFlags2,
  output logic [7:0] flags1,
  output logic [7:0] flags2,
  output logic       clearMode
);
  flagStrobes_t strobes;

  faultDetectCtl #(
    .LedShortTicks (LedShortTicks),
    .OutShortTicks (OutShortTicks),
    .OvpEdges      (OvpEdges)
  ) uCtl (
    .clk             (clk),
    .rstN            (rstN),
    .swReset         (swReset),
    .usTick          (usTick),
    .driverActive    (driverActive),
    .ledShortEn      (ledShortEn),
    .ntcShortEn      (ntcShortEn),
    .ntcOpenEn       (ntcOpenEn),
    .txEvt           (txEvt),
    .outShortDet     (outShortDet),
    .led1ShortDet    (led1ShortDet),
    .led2ShortDet    (led2ShortDet),
    .curLimDet       (curLimDet),
    .tsdDet          (tsdDet),
    .uvloDet         (uvloDet),
    .flashTimeoutEvt (flashTimeoutEvt),
    .ntcShortDet     (ntcShortDet),
    .ntcOpenDet      (ntcOpenDet),
    .ivfmTripDet     (ivfmTripDet),
    .ovpDet          (ovpDet),
    .tempTripDet     (tempTripDet),
    .rdFlags1        (rdFlags1),
    .rdFlags2        (rdFlags2),
    .strobes         (strobes)
  );

  flagDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .flags1    (flags1),
    .flags2    (flags2),
    .clearMode (clearMode)
  );
endmodule

// File: rtl/faultSupervisorChk.sv
module faultSupervisorChk (
  input logic       clk,
  input logic       rstN,
  input logic       swReset,
  input logic       driverActive,
  input logic       ledShortEn,
  input logic       txEvt,
  input logic       outShortDet,
  input logic       led1ShortDet,
  input logic       led2ShortDet,
  input logic       curLimDet,
  input logic       tsdDet,
  input logic       uvloDet,
  input logic       flashTimeoutEvt,
  input logic       ovpDet,
  input logic       rdFlags1,
  input logic [7:0] flags1,
  input logic [7:0] flags2,
  input logic       clearMode
);
  // R12
  sw_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (flags1 == 8'h00 && flags2 == 8'h00));

  // R4
  tsd_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tsdDet && !swReset) |=> clearMode);

  // R2
  curlim_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curLimDet && !swReset) |=> flags1[3]);

  // R5
  curlim_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags1 == 8'h08 && flags2 == 8'h00) |-> !clearMode);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlags1 && !txEvt && !outShortDet && !led1ShortDet && !led2ShortDet &&
     !curLimDet && !tsdDet && !uvloDet && !flashTimeoutEvt) |=> flags1 == 8'h00);

  // R10
  ovp_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags2[1]) |-> $past(ovpDet && driverActive));

  // R8
  led1_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags1[5]) |-> $past(led1ShortDet && driverActive && ledShortEn));
endmodule

bind faultSupervisor faultSupervisorChk uChk (
  .clk             (clk),
  .rstN            (rstN),
  .swReset         (swReset),
  .driverActive    (driverActive),
  .ledShortEn      (ledShortEn),
  .txEvt           (txEvt),
  .outShortDet     (outShortDet),
  .led1ShortDet    (led1ShortDet),
  .led2ShortDet    (led2ShortDet),
  .curLimDet       (curLimDet),
  .tsdDet          (tsdDet),
  .uvloDet         (uvloDet),
  .flashTimeoutEvt (flashTimeoutEvt),
  .ovpDet          (ovpDet),
  .rdFlags1        (rdFlags1),
  .flags1          (flags1),
  .flags2          (flags2),
  .clearMode       (clearMode)
);

// File: tb/faultSupervisor_test.sv
`timescale 1ns/1ps
module faultSupervisor_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, swReset, usTick, driverActive;
  logic ledShortEn, ntcShortEn, ntcOpenEn, rdFlags1, rdFlags2;
  logic [12:0] det;
  logic [7:0] flags1, flags2;
  logic clearMode;

  localparam int D_TX = 0, D_OSH = 1, D_L1 = 2, D_L2 = 3, D_CL = 4, D_TSD = 5,
                 D_UV = 6, D_TMO = 7, D_NSH = 8, D_NOP = 9, D_IVFM = 10,
                 D_OVP = 11, D_TEMP = 12;

  int checks = 0;
  int errors = 0;

  faultSupervisor uut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .usTick(usTick),
    .driverActive(driverActive), .ledShortEn(ledShortEn),
    .ntcShortEn(ntcShortEn), .ntcOpenEn(ntcOpenEn),
    .txEvt(det[D_TX]), .outShortDet(det[D_OSH]), .led1ShortDet(det[D_L1]),
    .led2ShortDet(det[D_L2]), .curLimDet(det[D_CL]), .tsdDet(det[D_TSD]),
    .uvloDet(det[D_UV]), .flashTimeoutEvt(det[D_TMO]),
    .ntcShortDet(det[D_NSH]), .ntcOpenDet(det[D_NOP]),
    .ivfmTripDet(det[D_IVFM]), .ovpDet(det[D_OVP]), .tempTripDet(det[D_TEMP]),
    .rdFlags1(rdFlags1), .rdFlags2(rdFlags2),
    .flags1(flags1), .flags2(flags2), .clearMode(clearMode)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int idx);
    det[idx] = 1'b1;
    cyc(1);
    det[idx] = 1'b0;
  endtask

  task automatic readF1;
    rdFlags1 = 1'b1; cyc(1); rdFlags1 = 1'b0;
  endtask

  task automatic readF2;
    rdFlags2 = 1'b1; cyc(1); rdFlags2 = 1'b0;
  endtask

  task automatic testReset;
    chk("R1", "flags1 after reset", flags1, 8'h00);
    chk("R1", "flags2 after reset", flags2, 8'h00);
    chk("R1", "clearMode after reset", {7'b0, clearMode}, 8'h00);
  endtask

  task automatic testFlags1Bits;
    int idx[5] = '{D_TX, D_CL, D_TMO, D_TSD, D_UV};
    logic [7:0] expv[5] = '{8'h80, 8'h08, 8'h01, 8'h04, 8'h02};
    logic forcing[5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    for (int i = 0; i < 5; i++) begin
      pulse(idx[i]);
      chk("R2", "flags1 bit position", flags1, expv[i]);
      chk(forcing[i] ? "R4" : "R5", "clearMode", {7'b0, clearMode}, {7'b0, forcing[i]});
      cyc(3);
      chk("R2", "flags1 held", flags1, expv[i]);
      readF1;
      chk("R6", "flags1 after read", flags1, 8'h00);
      chk("R6", "clearMode after read", {7'b0, clearMode}, 8'h00);
    end
  endtask

  task automatic testFlags2Bits;
    pulse(D_IVFM);
    chk("R3", "flags2 monitor trip bit", flags2, 8'h04);
    chk("R5", "monitor trip no standby", {7'b0, clearMode}, 8'h00);
    readF2;
    pulse(D_TEMP);
    chk("R3", "flags2 temp trip bit", flags2, 8'h01);
    chk("R4", "temp trip standby", {7'b0, clearMode}, 8'h01);
    readF2;
    chk("R6", "flags2 after read", flags2, 8'h00);
  endtask

  task automatic testTwoBytes;
    det[D_TSD] = 1'b1; det[D_TEMP] = 1'b1;
    cyc(1);
    det[D_TSD] = 1'b0; det[D_TEMP] = 1'b0;
    readF1;
    chk("R6", "flags1 cleared alone", flags1, 8'h00);
    chk("R6", "clearMode held by flags2", {7'b0, clearMode}, 8'h01);
    readF2;
    chk("R6", "clearMode after both reads", {7'b0, clearMode}, 8'h00);
  endtask

  task automatic testPersistent;
    det[D_TSD] = 1'b1;
    cyc(2);
    readF1;
    chk("R7", "flag reset while fault held", flags1, 8'h04);
    chk("R7", "standby while fault held", {7'b0, clearMode}, 8'h01);
    det[D_TSD] = 1'b0;
    cyc(1);
    readF1;
    chk("R7", "flag clears once fault gone", flags1, 8'h00);
  endtask

  task automatic testLedShort;
    driverActive = 1'b1; ledShortEn = 1'b1;
    det[D_L1] = 1'b1;
    cyc(255);
    chk("R8", "LED1 short before 256 ticks", flags1, 8'h00);
    cyc(1);
    chk("R8", "LED1 short at 256 ticks", flags1, 8'h20);
    chk("R4", "LED1 short standby", {7'b0, clearMode}, 8'h01);
    det[D_L1] = 1'b0; cyc(1); readF1;
    // glitch restarts the count
    det[D_L2] = 1'b1; cyc(200);
    det[D_L2] = 1'b0; cyc(1);
    det[D_L2] = 1'b1; cyc(255);
    chk("R8", "LED2 short count restarted", flags1, 8'h00);
    cyc(1);
    chk("R8", "LED2 short after restart", flags1, 8'h10);
    det[D_L2] = 1'b0; cyc(1); readF1;
    // missing ticks do not count
    det[D_L1] = 1'b1; cyc(100);
    usTick = 1'b0; cyc(200);
    usTick = 1'b1; cyc(155);
    chk("R8", "idle cycles not counted", flags1, 8'h00);
    cyc(1);
    chk("R8", "set after 256 real ticks", flags1, 8'h20);
    det[D_L1] = 1'b0; cyc(1); readF1;
    // disabled detection
    ledShortEn = 1'b0; det[D_L1] = 1'b1; cyc(300);
    chk("R8", "LED short disabled", flags1, 8'h00);
    ledShortEn = 1'b1; driverActive = 1'b0; cyc(300);
    chk("R8", "LED short while idle", flags1, 8'h00);
    det[D_L1] = 1'b0;
  endtask

  task automatic testOutShort;
    driverActive = 1'b1; ledShortEn = 1'b0;
    det[D_OSH] = 1'b1;
    cyc(2047);
    chk("R9", "output short before 2048 ticks", flags1, 8'h00);
    cyc(1);
    chk("R9", "output short at 2048 ticks", flags1, 8'h40);
    det[D_OSH] = 1'b0; cyc(1); readF1;
    driverActive = 1'b0; ledShortEn = 1'b1;
  endtask

  task automatic ovpPulses(int n);
    for (int i = 0; i < n; i++) begin
      pulse(D_OVP);
      cyc(1);
    end
  endtask

  task automatic testOvp;
    driverActive = 1'b1;
    ovpPulses(2);
    chk("R10", "two edges no flag", flags2, 8'h00);
    pulse(D_OVP);
    chk("R10", "third edge sets flag", flags2, 8'h02);
    chk("R4", "overvoltage standby", {7'b0, clearMode}, 8'h01);
    cyc(1); readF2;
    ovpPulses(2);
    driverActive = 1'b0; cyc(1); driverActive = 1'b1;
    ovpPulses(2);
    chk("R10", "standby zeroes edge count", flags2, 8'h00);
    pulse(D_OVP);
    chk("R10", "third edge after standby", flags2, 8'h02);
    cyc(1); readF2;
    ovpPulses(2);
    readF1;
    ovpPulses(2);
    chk("R10", "read zeroes edge count", flags2, 8'h00);
    pulse(D_OVP);
    chk("R10", "third edge after read", flags2, 8'h02);
    cyc(1); readF2;
    driverActive = 1'b0;
  endtask

  task automatic testNtc;
    pulse(D_NSH);
    chk("R11", "NTC short disabled", flags2, 8'h00);
    ntcShortEn = 1'b1;
    pulse(D_NSH);
    chk("R11", "NTC short enabled", flags2, 8'h10);
    chk("R4", "NTC short standby", {7'b0, clearMode}, 8'h01);
    readF2;
    pulse(D_NOP);
    chk("R11", "NTC open disabled", flags2, 8'h00);
    ntcOpenEn = 1'b1;
    pulse(D_NOP);
    chk("R11", "NTC open enabled", flags2, 8'h08);
    readF2;
    ntcShortEn = 1'b0; ntcOpenEn = 1'b0;
  endtask

  task automatic testSwReset;
    pulse(D_CL); pulse(D_TEMP);
    det[D_TSD] = 1'b1; swReset = 1'b1;
    cyc(1);
    swReset = 1'b0;
    chk("R12", "flags1 after swReset", flags1, 8'h00);
    chk("R12", "flags2 after swReset", flags2, 8'h00);
    det[D_TSD] = 1'b0;
    driverActive = 1'b1;
    det[D_L1] = 1'b1; cyc(200);
    swReset = 1'b1; cyc(1); swReset = 1'b0;
    cyc(255);
    chk("R12", "counter wiped by swReset", flags1, 8'h00);
    cyc(1);
    chk("R12", "full count after wipe", flags1, 8'h20);
    det[D_L1] = 1'b0; driverActive = 1'b0;
    cyc(1); readF1;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; swReset = 1'b0; usTick = 1'b1; driverActive = 1'b0;
    ledShortEn = 1'b1; ntcShortEn = 1'b0; ntcOpenEn = 1'b0;
    rdFlags1 = 1'b0; rdFlags2 = 1'b0; det = '0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testFlags1Bits();
    testFlags2Bits();
    testTwoBytes();
    testPersistent();
    testLedShort();
    testOutShort();
    testOvp();
    testNtc();
    testSwReset();
    finishRun();
  end
endmodule